// File: doc/BRIEF.md
# Phase-Aligned Selective Refresh Controller for an eDRAM Cache

This controller decides, line by line, when an on-chip eDRAM cache array needs a refresh. It also decides when a cold line should leave the cache instead of being kept alive. An external timer splits the retention period into equal phases and marks each new phase with a one-cycle `phase_tick`. Each line keeps four items of state: a valid flag, a dirty flag, the phase in which it was last touched, and a countdown of the refreshes it may still receive. A touch is either a cache access or a refresh.

At every phase tick the controller sweeps the line table in ascending index order, one line per clock. A valid line whose stored phase equals the new current phase has reached one full retention period since its last touch. If its countdown is nonzero, the line gets a refresh pulse and the countdown drops by one. If the countdown is zero, the line is retired instead. A dirty line gets a writeback request and a clean line gets an invalidate request. Either request is held until the array side accepts it.

Every access from the cache pipeline marks its line as freshly used and reloads the countdown. The reload value is the dirty grace count for a dirty line and the clean grace count for a clean line. The grace counts are configuration inputs. Data storage and array timing are not part of this block.

Top module: `edram_phase_refresh`

## Requirements
- R1: After reset `cur_phase` is 0, `rfsh_vld`, `wb_vld` and `inv_vld` are low, and every line is invalid, so phase sweeps issue no request until lines are accessed.
- R2: Each `phase_tick` increments `cur_phase` modulo 2^PH_W and starts a sweep from line 0. When no retire request stalls the sweep, line k is examined k+1 clocks after the tick edge, and its refresh pulse is visible right after that edge.
- R3: An access (`acc_vld`) makes line `acc_idx` valid and stores `cur_phase` as its phase. A write (`acc_wr`=1) sets its dirty flag, and a read keeps the line's previous dirty flag (false if the line was invalid). The countdown is reloaded with `dirty_grace` if the resulting line is dirty and with `clean_grace` otherwise.
- R4: A sweep acts only on valid lines whose stored phase equals `cur_phase`, so a line is first acted on at the fourth tick after its access (one retention period with PH_W=2).
- R5: An acted-on line with a nonzero countdown gets a one-cycle `rfsh_vld` pulse with `rfsh_idx` set to its index, and its countdown decreases by one.
- R6: An acted-on dirty line with countdown 0 raises `wb_vld` with `wb_idx`. Both are held stable until `wb_rdy` is seen, and the line is then invalid and never refreshed again.
- R7: An acted-on clean line with countdown 0 raises `inv_vld` with `inv_idx`. Both are held stable until `inv_rdy` is seen, and the line is then invalid.
- R8: While a writeback or invalidate request is outstanding, the sweep pauses: no refresh is issued. It resumes with the next line after the handshake.
- R9: An access to the very line the sweep examines in the same cycle wins. No refresh or retire is issued for that line in this sweep, and the access's state update is applied.
- R10: A grace count of 0 causes the line to be retired at its first matching sweep, with no refresh before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | One-cycle pulse from the retention timer marking a new phase |
| acc_vld | input | 1 | Cache access strobe |
| acc_idx | input | IDX_W | Index of the accessed line |
| acc_wr | input | 1 | Access is a write |
| dirty_grace | input | CNT_W | Refreshes granted to a dirty line before writeback |
| clean_grace | input | CNT_W | Refreshes granted to a clean line before invalidation |
| rfsh_vld | output | 1 | Refresh pulse for one line |
| rfsh_idx | output | IDX_W | Line to refresh |
| wb_vld | output | 1 | Writeback request, held until accepted |
| wb_idx | output | IDX_W | Line to write back |
| wb_rdy | input | 1 | Array accepts the writeback |
| inv_vld | output | 1 | Invalidate request, held until accepted |
| inv_idx | output | IDX_W | Line to invalidate |
| inv_rdy | input | 1 | Array accepts the invalidate |
| cur_phase | output | PH_W | Current phase number |

## Verification
A corrupted stored phase or valid flag shows up as a refresh at the wrong sweep position. It can also show up as a missing or extra refresh. Either way the error is visible within one retention period, that is, four ticks, after the line's last touch. A countdown that is off by one moves the writeback or invalidate a whole retention period earlier or later. A wrong retire kind swaps a writeback for an invalidate. A stall or collision fault shows up on the first sweep that meets an outstanding request or a same-cycle access, as an extra or out-of-place refresh pulse.

// File: rtl/edram_phase_refresh.sv
module edram_phase_refresh #(
  parameter int LINES = 64,
  parameter int CNT_W = 4,
  parameter int PH_W  = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_tick,
  input  logic             acc_vld,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_wr,
  input  logic [CNT_W-1:0] dirty_grace,
  input  logic [CNT_W-1:0] clean_grace,
  output logic             rfsh_vld,
  output logic [IDX_W-1:0] rfsh_idx,
  output logic             wb_vld,
  output logic [IDX_W-1:0] wb_idx,
  input  logic             wb_rdy,
  output logic             inv_vld,
  output logic [IDX_W-1:0] inv_idx,
  input  logic             inv_rdy,
  output logic [PH_W-1:0]  cur_phase
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  logic [LINES-1:0] valid, dirty;
  logic [PH_W-1:0]  ph  [LINES];
  logic [CNT_W-1:0] cnt [LINES];
  logic             scan_on;
  logic [IDX_W-1:0] scan_idx;

  wire stall   = wb_vld | inv_vld;
  wire collide = acc_vld && (acc_idx == scan_idx);
  wire hit     = valid[scan_idx] && (ph[scan_idx] == cur_phase) && !collide;
  wire step    = scan_on && !stall && !phase_tick;
  wire nd      = (valid[acc_idx] & dirty[acc_idx]) | acc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= '0;
      dirty     <= '0;
      for (int i = 0; i < LINES; i++) begin
        ph[i]  <= '0;
        cnt[i] <= '0;
      end
      scan_on   <= 1'b0;
      scan_idx  <= '0;
      cur_phase <= '0;
      rfsh_vld  <= 1'b0;
      rfsh_idx  <= '0;
      wb_vld    <= 1'b0;
      wb_idx    <= '0;
      inv_vld   <= 1'b0;
      inv_idx   <= '0;
    end else begin
      rfsh_vld <= 1'b0;
      if (phase_tick) begin
        cur_phase <= cur_phase + PH_W'(1);
        scan_on   <= 1'b1;
        scan_idx  <= '0;
      end else if (step) begin
        if (hit) begin
          if (cnt[scan_idx] != '0) begin
            rfsh_vld      <= 1'b1;
            rfsh_idx      <= scan_idx;
            cnt[scan_idx] <= cnt[scan_idx] - CNT_W'(1);
          end else if (dirty[scan_idx]) begin
            wb_vld <= 1'b1;
            wb_idx <= scan_idx;
          end else begin
            inv_vld <= 1'b1;
            inv_idx <= scan_idx;
          end
        end
        if (scan_idx == LAST) scan_on <= 1'b0;
        else scan_idx <= scan_idx + IDX_W'(1);
      end
      if (wb_vld && wb_rdy) begin
        wb_vld        <= 1'b0;
        valid[wb_idx] <= 1'b0;
        dirty[wb_idx] <= 1'b0;
      end
      if (inv_vld && inv_rdy) begin
        inv_vld        <= 1'b0;
        valid[inv_idx] <= 1'b0;
        dirty[inv_idx] <= 1'b0;
      end
      if (acc_vld) begin
        valid[acc_idx] <= 1'b1;
        dirty[acc_idx] <= nd;
        ph[acc_idx]    <= cur_phase;
        cnt[acc_idx]   <= nd ? dirty_grace : clean_grace;
      end
    end
  end

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |=> cur_phase == $past(cur_phase) + PH_W'(1));

  assert_scan_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_vld && $past(rfsh_vld)) |-> rfsh_idx == $past(rfsh_idx) + IDX_W'(1));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_on |=> !rfsh_vld);

  assert_one_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rfsh_vld, wb_vld, inv_vld}));

  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && !wb_rdy) |=> wb_vld && $stable(wb_idx));

  assert_inv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_vld && !inv_rdy) |=> inv_vld && $stable(inv_idx));
endmodule

// File: tb/sim_edram_phase_refresh.sv
module sim_edram_phase_refresh;
  localparam int LINES = 64, CNT_W = 4, PH_W = 2, IDX_W = $clog2(LINES);
  localparam int RF = 0, WB = 1, IV = 2;

  logic clk = 0, rst_n = 0, phase_tick = 0, acc_vld = 0, acc_wr = 0;
  logic [IDX_W-1:0] acc_idx = '0;
  logic [CNT_W-1:0] dirty_grace = 4'd2, clean_grace = 4'd1;
  logic wb_rdy = 1, inv_rdy = 1;
  logic rfsh_vld, wb_vld, inv_vld;
  logic [IDX_W-1:0] rfsh_idx, wb_idx, inv_idx;
  logic [PH_W-1:0] cur_phase;

  edram_phase_refresh u0 (.*);

  always #5 clk = ~clk;

  typedef struct { int kind; int idx; int cyc; string req; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) cyc <= phase_tick ? 0 : cyc + 1;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_ev(int kind, int idx, int c, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.cyc = c; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic observe(int kind, int idx);
    item_t it;
    if (exp_q.size() == 0) begin
      check(0, "unexpected request R4", kind * 1000 + idx, -1);
      return;
    end
    it = exp_q.pop_front();
    check(it.kind == kind && it.idx == idx, it.req, kind * 1000 + idx, it.kind * 1000 + it.idx);
    if (it.cyc >= 0) check(cyc == it.cyc, {it.req, " timing R2"}, cyc, it.cyc);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rfsh_vld) observe(RF, int'(rfsh_idx));
    if (wb_vld && wb_rdy) observe(WB, int'(wb_idx));
    if (inv_vld && inv_rdy) observe(IV, int'(inv_idx));
  end

  task automatic access(int idx, bit wr);
    @(negedge clk);
    acc_vld = 1; acc_idx = IDX_W'(idx); acc_wr = wr;
    @(negedge clk);
    acc_vld = 0; acc_wr = 0;
  endtask

  task automatic tick_and_sweep(int coll);
    @(negedge clk); phase_tick = 1;
    @(negedge clk); phase_tick = 0;
    if (coll >= 0) begin
      repeat (coll) @(negedge clk);
      acc_vld = 1; acc_idx = IDX_W'(coll); acc_wr = 0;
      @(negedge clk); acc_vld = 0;
    end
    repeat (LINES + 8) @(negedge clk);
  endtask

  task automatic quiet_ticks();
    repeat (3) tick_and_sweep(-1);
  endtask

  initial begin
    #(100000 * 10);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cur_phase == 0, "R1 phase", cur_phase, 0);
    check({rfsh_vld, wb_vld, inv_vld} == 0, "R1 requests", {rfsh_vld, wb_vld, inv_vld}, 0);
    rst_n = 1;
    // R1: empty table, a whole retention period of sweeps stays silent
    quiet_ticks();
    tick_and_sweep(-1);
    check(cur_phase == 0, "R2 phase wrap", cur_phase, 0);
    // R3: line 3 written (dirty, grace 2), lines 5 and 10 read (clean, grace 1)
    access(3, 1); access(5, 0); access(10, 0);
    quiet_ticks();
    check(cur_phase == 3, "R2 phase count", cur_phase, 3);
    expect_ev(RF, 3, 4, "R4 R5 refresh 3");
    expect_ev(RF, 5, 6, "R4 R5 refresh 5");
    expect_ev(RF, 10, 11, "R4 R5 refresh 10");
    tick_and_sweep(-1);
    check(exp_q.size() == 0, "R4 round A all seen", exp_q.size(), 0);
    quiet_ticks();
    // R9: read on line 3 collides with its sweep slot, R7 clean retires
    expect_ev(IV, 5, -1, "R7 invalidate 5");
    expect_ev(IV, 10, -1, "R7 invalidate 10");
    tick_and_sweep(3);
    check(exp_q.size() == 0, "R9 R7 round B", exp_q.size(), 0);
    quiet_ticks();
    expect_ev(RF, 3, 4, "R9 reloaded count refresh 3");
    tick_and_sweep(-1);
    // R10: zero grace retires on first matching sweep
    clean_grace = 0;
    access(40, 0);
    clean_grace = 1;
    quiet_ticks();
    expect_ev(RF, 3, 4, "R5 last refresh 3");
    expect_ev(IV, 40, -1, "R10 zero grace invalidate 40");
    tick_and_sweep(-1);
    check(exp_q.size() == 0, "R10 round D", exp_q.size(), 0);
    access(50, 0);
    quiet_ticks();
    // R6 R8: writeback stalls the sweep, line 50 refresh waits
    wb_rdy = 0;
    expect_ev(WB, 3, -1, "R6 writeback 3");
    expect_ev(RF, 50, -1, "R8 refresh 50 after stall");
    tick_and_sweep(-1);
    check(wb_vld == 1, "R6 wb held", wb_vld, 1);
    check(wb_idx == 3, "R6 wb index", wb_idx, 3);
    check(exp_q.size() == 2, "R8 no refresh during stall", exp_q.size(), 2);
    @(posedge clk); #2 wb_rdy = 1;
    repeat (LINES + 8) @(negedge clk);
    check(wb_vld == 0, "R6 wb released", wb_vld, 0);
    check(exp_q.size() == 0, "R8 sweep resumed", exp_q.size(), 0);
    quiet_ticks();
    // R6: line 3 gone after writeback; line 50 clean retire
    expect_ev(IV, 50, -1, "R7 invalidate 50");
    tick_and_sweep(-1);
    check(exp_q.size() == 0, "R6 final round", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule